// File: doc/BRIEF.md
# SMBus Slave Byte-Protocol Engine

A slave-only engine for a two-wire management bus. It runs on a fast system clock and oversamples the clock and data lines. It recognises bus START and STOP conditions, shifts in the address, command and data bytes most significant bit first, and answers through an open-drain pull-down on the data line. Four transfer shapes are handled: write-byte, send-byte, read-byte and receive-byte.

On the register side the engine presents a command pointer and a write strobe with its data byte. It also gives a strobe for a bare command (send-byte) and takes a read-data byte that it returns during read transfers. The pointer outlives the transfer that set it, so a later receive-byte returns the same register. The engine also answers the shared alert-response address, and only while an alert is pending. It then hands out its own address and signals that the alert was served. Register storage and alert generation live outside the block.

Top module: `smb_slave_engine`

## Requirements
- R1: SCL and SDA are synchronised and filtered. A level must hold for two consecutive synchronised samples before it is seen. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A one-clock SDA pulse while SCL is high is not taken as a START.
- R2: The address byte is bits 7:1 = address and bit 0 = R/W, with 0 meaning write. The engine acknowledges its own address in either direction. It acknowledges the alert-response address 7'b0001100 only when R/W=1 and `alert_pend_i` is high. Every other address gets no acknowledge and produces no strobe.
- R3: Write-byte (address W, command, data) acknowledges all three bytes. It sets `cmd_ptr_o` to the command byte and pulses `wr_stb_o` for one clock with `wr_data_o` equal to the data byte, received MSB first.
- R4: Send-byte (address W, command, STOP) sets `cmd_ptr_o` and pulses `cmd_stb_o` for one clock at the STOP. No write strobe is issued.
- R5: The pointer update and the write strobe take effect only after SCL falls at the end of the ninth (acknowledge) clock of their byte. During that clock's high phase nothing has changed yet.
- R6: A read address that is acknowledged returns `rd_data_i`, sampled at the end of the address acknowledge and sent MSB first, as one byte. SDA is released for the master's acknowledge bit and afterwards.
- R7: `cmd_ptr_o` is 0x00 after reset. A read (read-byte or receive-byte) returns the register at the pointer left by the most recent completed command byte.
- R8: A START or STOP that arrives while a command or data byte is only partly clocked in discards that byte. No strobe is issued and the pointer keeps its previous value.
- R9: An alert-response read returns {own address, 1'b0} and pulses `alert_taken_o` for one clock after the byte's ninth clock.
- R10: The own address is loaded from `addr_strap_i` on the first clock after reset and whenever `addr_resample_i` is high. A change of the strap alone has no effect.
- R11: After the data byte of a write-byte, further bytes are not acknowledged and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| addr_strap_i | input | 7 | Strapped own address value |
| addr_resample_i | input | 1 | Reload own address from strap |
| alert_pend_i | input | 1 | An alert is pending; enables alert-response answer |
| alert_taken_o | output | 1 | One-clock pulse: own address was handed out |
| cmd_ptr_o | output | 8 | Current command pointer |
| wr_stb_o | output | 1 | One-clock register write strobe |
| wr_data_o | output | 8 | Data byte for the write strobe |
| cmd_stb_o | output | 1 | One-clock send-byte command strobe |
| rd_data_i | input | 8 | Register contents at `cmd_ptr_o` |

## Verification
A wrong bit count or state shows up on the bus within one byte. The acknowledge lands on the wrong clock, or is missing, and the master sees it at the next ninth-clock sample. A corrupted shift or pointer shows at the next read, where the returned byte or the register selected differs from what the bench wrote. Commit timing is probed inside the acknowledge clock itself, so an early strobe is caught half a bus bit before the correct moment.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned SMB_ADDR_W = 7;
  localparam int unsigned SMB_BYTE_W = SMB_ADDR_W + 1;
  localparam logic [SMB_ADDR_W-1:0] SMB_ALERT_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_TX,
    ST_SKIP
  } smb_state_e;
endpackage

// File: rtl/smb_glitch_filt.sv
module smb_glitch_filt #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1, s2, s3;

  // two-flop sync, then accept a level only after two equal samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1  <= RST_VAL;
      s2  <= RST_VAL;
      s3  <= RST_VAL;
      q_o <= RST_VAL;
    end else begin
      s1 <= d_i;
      s2 <= s1;
      s3 <= s2;
      if (s2 == s3) q_o <= s3;
    end
  end
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/smb_slave_engine.sv
module smb_slave_engine
  import smb_pkg::*;
#(
  parameter int unsigned N_LINES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  input  logic [SMB_ADDR_W-1:0] addr_strap_i,
  input  logic                  addr_resample_i,
  input  logic                  alert_pend_i,
  output logic                  alert_taken_o,
  output logic [SMB_BYTE_W-1:0] cmd_ptr_o,
  output logic                  wr_stb_o,
  output logic [SMB_BYTE_W-1:0] wr_data_o,
  output logic                  cmd_stb_o,
  input  logic [SMB_BYTE_W-1:0] rd_data_i
);
  localparam int unsigned CNT_W = $clog2(SMB_BYTE_W + 2);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(SMB_BYTE_W);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(SMB_BYTE_W + 1);

  logic [N_LINES-1:0] line_raw, line_f;
  logic scl_f, sda_f;
  logic start, stop, scl_rise, scl_fall;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    smb_glitch_filt #(.RST_VAL(1'b1)) i_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_raw[g]),
      .q_o    (line_f[g])
    );
  end

  assign scl_f = line_f[1];
  assign sda_f = line_f[0];

  smb_bus_cond i_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_f),
    .sda_i      (sda_f),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  // own address latch
  logic [SMB_ADDR_W-1:0] own_addr;
  logic                  strap_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_addr <= '0;
      strap_ok <= 1'b0;
    end else begin
      if (!strap_ok || addr_resample_i) own_addr <= addr_strap_i;
      strap_ok <= 1'b1;
    end
  end

  smb_state_e            state;
  logic [CNT_W-1:0]      cnt;
  logic [SMB_BYTE_W-1:0] sh, tx_sh, tx_val;
  logic                  is_alert;
  logic                  own_hit, alert_hit, addr_hit, rw;

  assign rw        = sh[0];
  assign own_hit   = sh[SMB_BYTE_W-1:1] == own_addr;
  assign alert_hit = rw && alert_pend_i && (sh[SMB_BYTE_W-1:1] == SMB_ALERT_ADDR);
  assign addr_hit  = own_hit || alert_hit;
  assign tx_val    = alert_hit ? {own_addr, 1'b0} : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      sh            <= '0;
      tx_sh         <= '0;
      is_alert      <= 1'b0;
      sda_pull_o    <= 1'b0;
      cmd_ptr_o     <= '0;
      wr_stb_o      <= 1'b0;
      wr_data_o     <= '0;
      cmd_stb_o     <= 1'b0;
      alert_taken_o <= 1'b0;
    end else begin
      wr_stb_o      <= 1'b0;
      cmd_stb_o     <= 1'b0;
      alert_taken_o <= 1'b0;
      if (start) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop) begin
        // only the stop's own SCL rise after the command ack: send-byte
        if (state == ST_DATA && cnt == CNT_W'(1)) cmd_stb_o <= 1'b1;
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (scl_rise && state != ST_IDLE && state != ST_SKIP) begin
        if (cnt < ACK_CNT) sh <= {sh[SMB_BYTE_W-2:0], sda_f};
        cnt <= cnt + 1'b1;
      end else if (scl_fall && state != ST_IDLE && state != ST_SKIP) begin
        if (cnt == ACK_CNT) begin
          unique case (state)
            ST_ADDR:         sda_pull_o <= addr_hit;
            ST_CMD, ST_DATA: sda_pull_o <= 1'b1;
            default:         sda_pull_o <= 1'b0;
          endcase
        end else if (cnt == END_CNT) begin
          cnt        <= '0;
          sda_pull_o <= 1'b0;
          unique case (state)
            ST_ADDR: begin
              if (!addr_hit) state <= ST_SKIP;
              else if (rw) begin
                state      <= ST_TX;
                tx_sh      <= tx_val;
                is_alert   <= alert_hit;
                sda_pull_o <= ~tx_val[SMB_BYTE_W-1];
              end else state <= ST_CMD;
            end
            ST_CMD: begin
              cmd_ptr_o <= sh;
              state     <= ST_DATA;
            end
            ST_DATA: begin
              wr_stb_o  <= 1'b1;
              wr_data_o <= sh;
              state     <= ST_SKIP;
            end
            default: begin
              if (state == ST_TX && is_alert) alert_taken_o <= 1'b1;
              state <= ST_SKIP;
            end
          endcase
        end else if (state == ST_TX) begin
          tx_sh      <= {tx_sh[SMB_BYTE_W-2:0], 1'b0};
          sda_pull_o <= ~tx_sh[SMB_BYTE_W-2];
        end
      end
    end
  end

  p_wr_after_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(scl_fall));
  p_ptr_moves_on_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_ptr_o) |-> $past(scl_fall));
  p_cmd_stb_at_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |-> $past(stop));
  p_idle_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_pull_o);
  p_alert_after_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_taken_o |-> $past(scl_fall));
  p_pull_moves_on_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> $past(scl_fall || start || stop));
endmodule

// File: tb/test_smb_slave_engine.sv
module test_smb_slave_engine;
  localparam int QTR = 10;
  localparam logic [6:0] OWN_A = 7'h22;
  localparam logic [6:0] NEW_A = 7'h35;
  localparam logic [6:0] ARA   = 7'h0C;
  localparam logic [15:0] VECS [6] = '{16'h00A5, 16'h033C, 16'h05FF,
                                       16'h0100, 16'h7F81, 16'hFE5A};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk_i = ~clk_i;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] strap = OWN_A;
  logic resample = 1'b0, pend = 1'b0;
  logic sda_pull, alert_taken, wr_stb, cmd_stb;
  logic [7:0] cmd_ptr, wr_data, rd_data;
  logic sda_line;
  assign sda_line = sda_m & ~sda_pull;

  smb_slave_engine i_smb_slave_engine (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .scl_i           (scl_m),
    .sda_i           (sda_line),
    .sda_pull_o      (sda_pull),
    .addr_strap_i    (strap),
    .addr_resample_i (resample),
    .alert_pend_i    (pend),
    .alert_taken_o   (alert_taken),
    .cmd_ptr_o       (cmd_ptr),
    .wr_stb_o        (wr_stb),
    .wr_data_o       (wr_data),
    .cmd_stb_o       (cmd_stb),
    .rd_data_i       (rd_data)
  );

  // external register model
  logic [7:0] regs [256];
  int wr_cnt, cmd_cnt, alert_cnt;
  logic [7:0] last_cmd;
  assign rd_data = regs[cmd_ptr];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'(i * 3 + 1);
      wr_cnt <= 0; cmd_cnt <= 0; alert_cnt <= 0; last_cmd <= '0;
    end else begin
      if (wr_stb) begin regs[cmd_ptr] <= wr_data; wr_cnt <= wr_cnt + 1; end
      if (cmd_stb) begin cmd_cnt <= cmd_cnt + 1; last_cmd <= cmd_ptr; end
      if (alert_taken) alert_cnt <= alert_cnt + 1;
    end
  end

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 180000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QTR) @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic byte_out(input logic [7:0] v, output logic nack);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(nack);
  endtask

  task automatic byte_in(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(nack);
  endtask

  task automatic write_byte(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d,
                            output logic nack);
    logic n0, n1, n2;
    bus_start(); byte_out({a, 1'b0}, n0); byte_out(c, n1); byte_out(d, n2); bus_stop();
    nack = n0 | n1 | n2;
  endtask

  task automatic read_byte(input logic [6:0] a, input logic [7:0] c, output logic [7:0] d,
                           output logic nack);
    logic n0, n1, n2;
    bus_start(); byte_out({a, 1'b0}, n0); byte_out(c, n1);
    bus_start(); byte_out({a, 1'b1}, n2); byte_in(d, 1'b1); bus_stop();
    nack = n0 | n1 | n2;
  endtask

  task automatic recv_byte(input logic [6:0] a, output logic [7:0] d, output logic nack);
    bus_start(); byte_out({a, 1'b1}, nack);
    if (!nack) byte_in(d, 1'b1); else d = 8'hxx;
    bus_stop();
  endtask

  task automatic send_byte(input logic [6:0] a, input logic [7:0] c, output logic nack);
    logic n0, n1;
    bus_start(); byte_out({a, 1'b0}, n0); byte_out(c, n1); bus_stop();
    nack = n0 | n1;
  endtask

  initial begin
    logic nk, n0, n1;
    logic [7:0] d;
    int w0, c0, a0;

    repeat (3) @(negedge clk_i);
    chk("R7 ptr in reset", 32'(cmd_ptr), 32'h00);
    chk("R6 sda released in reset", 32'(sda_pull), 32'h0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R3 no write after reset", wr_cnt, 0);

    // R7: receive-byte right after reset reads register 0
    recv_byte(OWN_A, d, nk);
    chk("R7 recv ack", 32'(nk), 32'h0);
    chk("R7 recv reg0", 32'(d), 32'h01);

    // R3 / R6: table of write then read-back
    for (int v = 0; v < 6; v++) begin
      w0 = wr_cnt;
      write_byte(OWN_A, VECS[v][15:8], VECS[v][7:0], nk);
      chk("R3 write acked", 32'(nk), 32'h0);
      chk("R3 one strobe", wr_cnt, w0 + 1);
      read_byte(OWN_A, VECS[v][15:8], d, nk);
      chk("R6 read data", 32'(d), 32'(VECS[v][7:0]));
      chk("R7 pointer kept", 32'(cmd_ptr), 32'(VECS[v][15:8]));
    end

    // R7: receive-byte reuses pointer of last read-byte (0xFE)
    recv_byte(OWN_A, d, nk);
    chk("R7 recv reuses ptr", 32'(d), 32'h5A);

    // R5: commit only after ack clock falls
    w0 = wr_cnt;
    bus_start(); byte_out({OWN_A, 1'b0}, n0); byte_out(8'h10, n1);
    for (int i = 7; i >= 0; i--) bit_out(d_const(i));
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    chk("R5 ack during 9th clock", 32'(sda_line), 32'h0);
    chk("R5 no strobe before fall", wr_cnt, w0);
    q(); scl_m = 1'b0; q();
    chk("R5 strobe after fall", wr_cnt, w0 + 1);
    bus_stop();
    read_byte(OWN_A, 8'h10, d, nk);
    chk("R5 committed data", 32'(d), 32'hC3);

    // R11: extra byte after data is not acked
    w0 = wr_cnt;
    bus_start(); byte_out({OWN_A, 1'b0}, n0); byte_out(8'h11, n1); byte_out(8'h22, nk);
    byte_out(8'h33, nk); bus_stop();
    chk("R11 extra byte nack", 32'(nk), 32'h1);
    chk("R11 single strobe", wr_cnt, w0 + 1);
    read_byte(OWN_A, 8'h11, d, nk);
    chk("R11 first data kept", 32'(d), 32'h22);

    // R8: STOP mid data byte
    w0 = wr_cnt; c0 = cmd_cnt;
    bus_start(); byte_out({OWN_A, 1'b0}, n0); byte_out(8'h20, n1);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_stop();
    chk("R8 stop mid data no write", wr_cnt, w0);
    chk("R8 stop mid data no cmd", cmd_cnt, c0);
    chk("R8 ptr from full cmd", 32'(cmd_ptr), 32'h20);

    // R8: STOP mid command byte
    bus_start(); byte_out({OWN_A, 1'b0}, n0);
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    bus_stop();
    chk("R8 partial cmd ignored", 32'(cmd_ptr), 32'h20);
    chk("R8 partial cmd no strobe", cmd_cnt, c0);

    // R8: repeated START mid data byte
    bus_start(); byte_out({OWN_A, 1'b0}, n0); byte_out(8'h21, n1);
    for (int i = 0; i < 3; i++) bit_out(1'b1);
    bus_start(); byte_out({7'h40, 1'b0}, nk); bus_stop();
    chk("R8 restart mid data no write", wr_cnt, w0);
    read_byte(OWN_A, 8'h21, d, nk);
    chk("R8 reg untouched", 32'(d), 32'(8'(8'h21 * 3 + 1)));

    // R4: send-byte
    c0 = cmd_cnt; w0 = wr_cnt;
    send_byte(OWN_A, 8'h08, nk);
    chk("R4 send acked", 32'(nk), 32'h0);
    chk("R4 cmd strobe", cmd_cnt, c0 + 1);
    chk("R4 cmd value", 32'(last_cmd), 32'h08);
    chk("R4 no write strobe", wr_cnt, w0);

    // R2: address filtering
    w0 = wr_cnt;
    write_byte(7'h23, 8'h30, 8'h77, nk);
    chk("R2 foreign addr nack", 32'(nk), 32'h1);
    chk("R2 foreign no strobe", wr_cnt, w0);
    recv_byte(ARA, d, nk);
    chk("R2 alert addr nack when idle", 32'(nk), 32'h1);
    pend = 1'b1;
    bus_start(); byte_out({ARA, 1'b0}, nk); bus_stop();
    chk("R2 alert addr write nack", 32'(nk), 32'h1);

    // R9: alert response
    a0 = alert_cnt;
    recv_byte(ARA, d, nk);
    chk("R9 alert acked", 32'(nk), 32'h0);
    chk("R9 alert returns own addr", 32'(d), 32'({OWN_A, 1'b0}));
    chk("R9 alert taken pulse", alert_cnt, a0 + 1);
    pend = 1'b0;

    // R10: strap change alone does nothing; resample applies it
    strap = NEW_A;
    repeat (4) @(negedge clk_i);
    recv_byte(NEW_A, d, nk);
    chk("R10 strap alone ignored", 32'(nk), 32'h1);
    resample = 1'b1; @(negedge clk_i); resample = 1'b0;
    recv_byte(OWN_A, d, nk);
    chk("R10 old addr dropped", 32'(nk), 32'h1);
    recv_byte(NEW_A, d, nk);
    chk("R10 new addr acked", 32'(nk), 32'h0);

    // R1: one-clock SDA glitch while SCL high is no START
    q();
    @(negedge clk_i) sda_m = 1'b0;
    @(negedge clk_i) sda_m = 1'b1;
    q(); scl_m = 1'b0; q();
    byte_out({NEW_A, 1'b0}, nk);
    bus_stop();
    chk("R1 glitch not a start", 32'(nk), 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic logic d_const(input int i);
    logic [7:0] v;
    v = 8'hC3;
    return v[i];
  endfunction
endmodule